// File: doc/BRIEF.md
# Sample-Rate to Log-Pitch Converter

This block turns an integer sample rate in hertz into a 32-bit fixed-point logarithmic pitch word. The rate is first multiplied by a fixed scale factor, so that 48000 Hz lands on a known constant. The position of the most significant set bit of that product gives the integer octave part. The seven bits just below that leading one select an entry in a 128-entry magnitude table and an entry in a 128-entry slope table. The next seven bits are multiplied by the slope entry, and the result is added to the magnitude entry to give a linearly interpolated fraction of the octave.

The block has three pipeline stages: scale, normalise, then table lookup with multiply-add. A new rate is taken every cycle through a valid/ready input. Each result appears on a valid-qualified output exactly three cycles after its input was accepted. Both tables are built from their defining formulas when the design is elaborated, so no table contents appear in the source.

Top module: `rate_pitch_conv`

## Requirements
- R1: An accepted rate of zero produces a pitch of 0x00000000.
- R2: The rate is multiplied by the scale factor 11185 and truncated to its low 32 bits (the product is taken modulo 2^32). A rate of 48000 therefore gives the product 0x20002380 and the pitch 0x00E00000.
- R3: The octave term is (p - 15) * 2^20 modulo 2^32, where p is the position of the highest set bit of the product, searched from bit 31 down to bit 1. Positions below 15 give a wrapped, negative term.
- R4: The product is shifted left so that its leading one sits at bit 31. Bits 30:24 of the shifted value form the index k, and the same k addresses both tables. Bits 23:17 of the shifted value form the fraction f.
- R5: The magnitude entry mag[k] is the 20-bit value floor(2^20 * log2(1 + k/128)), computed by successive squaring. Start with y = (128 + k) * 2^23, a Q.30 value. For each result bit from bit 19 down to bit 0: set y = floor(y*y / 2^30); if y >= 2^31, halve y and set that result bit to 1.
- R6: The slope entry slope[k] is (mag[k+1] - mag[k] + 64) >> 7, with mag[128] taken as 2^20.
- R7: The pitch is the octave term plus mag[k] plus f * slope[k], summed modulo 2^32.
- R8: When bits 31:1 of the product are all zero (the product is 0 or 1), the pitch is 0x00000000.
- R9: out_valid is high in exactly the cycle three clock edges after a rate was accepted (in_valid and in_ready both high at an edge). The pitch for that rate is present on out_pitch in that same cycle.
- R10: in_ready is low during reset and high from the first edge after reset. Back-to-back rates are accepted every cycle, and results come out in input order. No output appears for a cycle in which no rate was accepted.
- R11: Synchronous active-high reset clears all pipeline valid flags, so out_valid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A rate is offered |
| in_ready | output | 1 | The block can accept a rate this cycle |
| in_rate | input | 32 | Sample rate in Hz |
| out_valid | output | 1 | out_pitch holds a result |
| out_pitch | output | 32 | Fixed-point log pitch |

## Verification
The hardest situations to reach from the ports are specific scaled products. These include a product of exactly 1, which must give zero, and products whose normalised index and fraction hit every table entry. None of these products shows up for ordinary rates. The bench computes the multiplicative inverse of the scale factor modulo 2^32 and multiplies each wanted product by it. This gives a rate whose truncated product is exactly the wanted value. With these rates it sweeps all 128 indices at fraction 0 and at fraction 127, back to back, as well as the product-equals-one case.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int RATE_W   = 32;
    localparam int POS_W    = $clog2(RATE_W);
    localparam int IDX_W    = 7;
    localparam int FRAC_W   = 7;
    localparam int MAG_W    = 20;
    localparam int SLOPE_W  = 8;
    localparam int OCT_POS  = 20;
    localparam int OCT_BIAS = 15;
    localparam int TBL_N    = 1 << IDX_W;
    localparam int QBITS    = 30;
    localparam int PROD_W   = FRAC_W + SLOPE_W;

    typedef struct packed {
        logic              vld;
        logic [RATE_W-1:0] prod;
    } scaled_t;

    typedef struct packed {
        logic              vld;
        logic              zero;
        logic [RATE_W-1:0] oct;
        logic [IDX_W-1:0]  idx;
        logic [FRAC_W-1:0] frac;
    } normed_t;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } lod_t;

    // highest set bit among positions RATE_W-1 .. 1
    function automatic lod_t lead_one(logic [RATE_W-1:0] v);
        lod_t r;
        r = '0;
        for (int p = 1; p < RATE_W; p++) begin
            if (v[p]) begin
                r.hit = 1'b1;
                r.pos = POS_W'(p);
            end
        end
        return r;
    endfunction

    // floor(2^MAG_W * log2(1 + k/TBL_N)) by successive squaring
    function automatic logic [MAG_W-1:0] mag_entry(int k);
        logic [63:0]      y;
        logic [MAG_W-1:0] r;
        y = 64'(TBL_N + k) << (QBITS - IDX_W);
        r = '0;
        for (int b = MAG_W - 1; b >= 0; b--) begin
            y = (y * y) >> QBITS;
            if (y >= (64'd2 << QBITS)) begin
                y    = y >> 1;
                r[b] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [SLOPE_W-1:0] slope_entry(int k);
        logic [MAG_W:0] nxt;
        logic [MAG_W:0] diff;
        nxt  = (k == TBL_N - 1) ? (MAG_W+1)'(1) << MAG_W
                                : {1'b0, mag_entry(k + 1)};
        diff = nxt - {1'b0, mag_entry(k)} + (MAG_W+1)'(1 << (FRAC_W - 1));
        return SLOPE_W'(diff >> FRAC_W);
    endfunction

endpackage

// File: rtl/rp_scale.sv
module rp_scale
    import rp_pkg::*;
#(
    parameter int SCALE = 11185
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic [RATE_W-1:0] rate_i,
    output scaled_t           s1_o
);
    localparam logic [RATE_W-1:0] SCALE_V = RATE_W'(SCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_o <= '0;
        end else begin
            s1_o.vld  <= fire_i;
            s1_o.prod <= rate_i * SCALE_V;
        end
    end

endmodule

// File: rtl/rp_norm.sv
module rp_norm
    import rp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  scaled_t s1_i,
    output normed_t s2_o
);
    lod_t              lod;
    logic [RATE_W-1:0] shifted;
    logic [RATE_W-1:0] oct_term;

    always_comb begin
        lod      = lead_one(s1_i.prod);
        shifted  = s1_i.prod << (POS_W'(RATE_W - 1) - lod.pos);
        oct_term = (RATE_W'(lod.pos) - RATE_W'(OCT_BIAS)) << OCT_POS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_o <= '0;
        end else begin
            s2_o.vld  <= s1_i.vld;
            s2_o.zero <= ~lod.hit;
            s2_o.oct  <= oct_term;
            s2_o.idx  <= shifted[RATE_W-2 -: IDX_W];
            s2_o.frac <= shifted[RATE_W-2-IDX_W -: FRAC_W];
        end
    end

    AST_NORM_MSB: assert property (@(posedge clk) disable iff (rst)
        (s1_i.vld && lod.hit) |-> shifted[RATE_W-1]); // R4

endmodule

// File: rtl/rp_interp.sv
module rp_interp
    import rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  normed_t           s2_i,
    output logic              out_vld_o,
    output logic [RATE_W-1:0] out_pitch_o
);
    logic [MAG_W-1:0]   mag_rom   [TBL_N];
    logic [SLOPE_W-1:0] slope_rom [TBL_N];

    for (genvar k = 0; k < TBL_N; k++) begin : g_rom
        localparam logic [MAG_W-1:0]   MV = mag_entry(k);
        localparam logic [SLOPE_W-1:0] SV = slope_entry(k);
        assign mag_rom[k]   = MV;
        assign slope_rom[k] = SV;
    end

    logic [PROD_W-1:0] interp;
    logic [RATE_W-1:0] total;

    always_comb begin
        interp = PROD_W'(s2_i.frac) * PROD_W'(slope_rom[s2_i.idx]);
        total  = s2_i.oct + RATE_W'(mag_rom[s2_i.idx]) + RATE_W'(interp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_o   <= 1'b0;
            out_pitch_o <= '0;
        end else begin
            out_vld_o   <= s2_i.vld;
            out_pitch_o <= s2_i.zero ? '0 : total;
        end
    end

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        $past(s2_i.vld && s2_i.zero) |-> (out_vld_o && out_pitch_o == '0)); // R8

endmodule

// File: rtl/rate_pitch_conv.sv
module rate_pitch_conv
    import rp_pkg::*;
#(
    parameter int SCALE = 11185
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [RATE_W-1:0] in_rate,
    output logic              out_valid,
    output logic [RATE_W-1:0] out_pitch
);
    scaled_t s1;
    normed_t s2;
    logic    fire;

    always_ff @(posedge clk) begin
        if (rst) in_ready <= 1'b0;
        else     in_ready <= 1'b1;
    end

    assign fire = in_valid && in_ready && !rst;

    rp_scale #(.SCALE(SCALE)) u_scale (
        .clk(clk), .rst(rst), .fire_i(fire), .rate_i(in_rate), .s1_o(s1)
    );

    rp_norm u_norm (
        .clk(clk), .rst(rst), .s1_i(s1), .s2_o(s2)
    );

    rp_interp u_interp (
        .clk(clk), .rst(rst), .s2_i(s2),
        .out_vld_o(out_valid), .out_pitch_o(out_pitch)
    );

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(fire, 3)); // R9

    AST_ZERO_RATE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(fire && in_rate == '0, 3)) |-> out_pitch == '0); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R11

endmodule

// File: tb/test_rate_pitch_conv.sv
module test_rate_pitch_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_rate = '0;
    logic        out_valid;
    logic [31:0] out_pitch;

    always #4 clk = ~clk;

    rate_pitch_conv i_rate_pitch_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_rate(in_rate), .out_valid(out_valid), .out_pitch(out_pitch)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    int          when_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // bench model of the spec
    function automatic int unsigned bm_mag(int k);
        longint unsigned v;
        int unsigned acc;
        v = longint'(128 + k) << 23;
        acc = 0;
        repeat (20) begin
            v = (v * v) >> 30;
            acc = acc << 1;
            if (v >= 64'h8000_0000) begin
                v = v >> 1;
                acc = acc | 1;
            end
        end
        return acc;
    endfunction

    function automatic int unsigned bm_slope(int k);
        int unsigned nx;
        nx = (k == 127) ? 32'h0010_0000 : bm_mag(k + 1);
        return (nx - bm_mag(k) + 64) >> 7;
    endfunction

    function automatic logic [31:0] bm_pitch(logic [31:0] rate);
        logic [31:0] prod, sh;
        int top, k, f;
        prod = rate * 32'd11185;
        if ((prod >> 1) == 0) return 32'h0;
        top = 1;
        for (int p = 31; p >= 1; p--) begin
            if (prod[p]) begin top = p; break; end
        end
        sh = prod << (31 - top);
        k = int'(sh[30:24]);
        f = int'(sh[23:17]);
        return (32'(top - 15) << 20) + bm_mag(k) + 32'(f) * bm_slope(k);
    endfunction

    function automatic logic [31:0] inv_scale();
        logic [31:0] x;
        x = 32'd11185;
        repeat (5) x = x * (32'd2 - 32'd11185 * x);
        return x;
    endfunction

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
        end
    endtask

    // driver: one rate per call, inputs change at negedge
    task automatic send(logic [31:0] rate, string tag, logic [31:0] fixed_exp, bit use_fixed);
        in_valid = 1'b1;
        in_rate  = rate;
        exp_q.push_back(use_fixed ? fixed_exp : bm_pitch(rate));
        when_q.push_back(cyc);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        in_rate  = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R10 output with nothing accepted", out_pitch, 32'h0);
            end else begin
                logic [31:0] e;
                int w;
                string t;
                e = exp_q.pop_front();
                w = when_q.pop_front();
                t = tag_q.pop_front();
                check(out_pitch == e, t, out_pitch, e);
                check(cyc == w + 3, {"R9 latency ", t}, 32'(cyc - w), 32'd3);
            end
        end
    end

    initial begin
        logic [31:0] inv;
        inv = inv_scale();
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid during reset", 32'(out_valid), 32'h0);
        check(in_ready == 1'b0, "R10 in_ready during reset", 32'(in_ready), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'h1);
        check(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'h0);

        send(32'd48000, "R2 R3 rate 48000", 32'h00E0_0000, 1);
        idle(5);
        send(32'd0, "R1 zero rate", 32'h0, 1);
        idle(5);
        send(inv, "R8 product equals one", 32'h0, 1);
        idle(5);
        send(32'd1, "R3 negative octave rate 1", 32'h0, 0);
        idle(2);
        send(32'd8000,   "R7 rate 8000",   32'h0, 0);
        send(32'd11025,  "R7 rate 11025",  32'h0, 0);
        send(32'd22050,  "R7 rate 22050",  32'h0, 0);
        send(32'd44100,  "R7 rate 44100",  32'h0, 0);
        send(32'd96000,  "R7 rate 96000",  32'h0, 0);
        send(32'd192000, "R7 rate 192000", 32'h0, 0);
        send(32'h0012_3457, "R2 wrapped product", 32'h0, 0);
        send(32'd0, "R1 zero back to back", 32'h0, 1);
        idle(4);
        // every table entry at fraction 0 and 127, back to back
        for (int k = 0; k < 128; k++) begin
            logic [31:0] target;
            target = {1'b1, 7'(k), 7'd0, 17'd0};
            send(target * inv, "R4 R5 index sweep f=0",
                 32'h0100_0000 + bm_mag(k), 1);
        end
        for (int k = 0; k < 128; k++) begin
            logic [31:0] target;
            target = {1'b1, 7'(k), 7'd127, 17'd0};
            send(target * inv, "R6 R7 index sweep f=127",
                 32'h0100_0000 + bm_mag(k) + 32'd127 * bm_slope(k), 1);
        end
        // low leading-one positions
        for (int p = 1; p < 31; p += 3) begin
            logic [31:0] target;
            target = (32'h1 << p) | 32'h1;
            send(target * inv, "R3 R4 low leading one", 32'h0, 0);
        end
        idle(10);
        check(exp_q.size() == 0, "R10 all results delivered", 32'(exp_q.size()), 32'h0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule